// File: doc/BRIEF.md
# Analog Output Routing and Scaling Engine

This block sits between the internally computed simulation quantities and a bank of analog output converters. Every output channel picks one value from a shared pool of sources: the internal measurements plus a configurable number of signals written by the host processor. Any source may drive any channel, and one source may drive several channels. Each channel then multiplies its source by its own gain, adds its own offset and limits the result to its own lower and upper bound. A negative gain is allowed, so a second channel can carry the inverted half of a differential signal.

All channels share one multiply-add pipeline. A sample tick starts a sweep that handles the channels in ascending order, one per clock, and each result leaves with a valid strobe and its channel index. Settings arrive through a simple write port into a shadow copy, and are copied into the working copy only when a sample tick is accepted. A sweep therefore never mixes old and new settings, and settings can change while the other channels keep running. The source pool is captured at the same tick, so one sweep sees one consistent set of inputs.

Values, offsets and bounds are signed 16-bit numbers with 12 fraction bits. Gain uses the same format. The product is kept at full width, the offset is added, the bounds are applied, and only then is the result cut back to 16 bits by dropping the fraction bits (rounding toward minus infinity).

Top module: `aout_router`

## Requirements
- R1: While reset is asserted `resValid` is 0. Until the first write, every channel has source 0, gain 0, offset 0, lower bound -32768 and upper bound 32767, so the first sweep after reset yields 0 on every channel.
- R2: A sample tick that arrives while no sweep is running starts a sweep. The sweep yields exactly NUM_CH results on consecutive cycles, with channel indices 0, 1, ..., NUM_CH-1 in that order.
- R3: A sample tick that arrives while a sweep is running is ignored: it neither restarts the sweep nor adds results.
- R4: Source index values 0..NUM_MEAS-1 select measurement inputs (measurement k sits in `measIn[16k+15:16k]`). Values NUM_MEAS..NUM_MEAS+NUM_USER-1 select user inputs in the same packed order in `userIn`. Several channels may use the same source. All sources are captured at the accepted tick, so input changes during a sweep do not affect it.
- R5: A source index of NUM_MEAS+NUM_USER or more selects the value 0.
- R6: The result before limiting is source*gain + offset*4096, computed at full width. The output is that value after limiting, divided by 4096 and rounded toward minus infinity. Negative gains are supported.
- R7: The output is never above the channel's upper bound and never below its lower bound when the lower bound does not exceed the upper bound.
- R8: When the lower bound is programmed above the upper bound, the output equals the upper bound.
- R9: A write with `cfgWrEn`=1 stores `cfgData` into the shadow setting of channel `cfgChan` selected by `cfgField`: 0 source index (low 8 bits), 1 gain, 2 offset, 3 lower bound, 4 upper bound. Field codes 5 to 7 change nothing. A stored setting is used from the next accepted tick onward. A write on the same clock edge as an accepted tick is applied at the tick after that.
- R10: Writes made while a sweep runs do not change the results of that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Start-of-sample pulse |
| measIn | input | 16*NUM_MEAS | Packed internal measurements, Q4.12 |
| userIn | input | 16*NUM_USER | Packed host user signals, Q4.12 |
| cfgWrEn | input | 1 | Setting write strobe |
| cfgChan | input | $clog2(NUM_CH) | Channel addressed by the write |
| cfgField | input | 3 | Setting selector (see R9) |
| cfgData | input | 16 | Setting value |
| resValid | output | 1 | Result strobe |
| resChan | output | $clog2(NUM_CH) | Channel of the current result |
| resData | output | 16 | Scaled and limited result, Q4.12 |

## Verification
The case that needs care is a setting write that lands on the same clock edge as an accepted sample tick. The write must land in the shadow copy but miss the working copy captured at that edge. The bench drives both strobes in one cycle, and its model copies the old shadow before applying the write. It then expects the old value for that sweep and the new value one sweep later. A second collision, a write during a running sweep, is handled the same way and is judged by comparing every result of both sweeps through the scoreboard.

// File: rtl/aout_router_pkg.sv
package aout_router_pkg;

  localparam int DATA_W = 16;
  localparam int FRAC_W = 12;
  localparam int CHAN_W_MAX = 5;

  localparam logic [2:0] FLD_SEL    = 3'd0;
  localparam logic [2:0] FLD_GAIN   = 3'd1;
  localparam logic [2:0] FLD_OFFSET = 3'd2;
  localparam logic [2:0] FLD_MIN    = 3'd3;
  localparam logic [2:0] FLD_MAX    = 3'd4;

  typedef struct packed {
    logic                     commit;
    logic                     issue;
    logic [CHAN_W_MAX-1:0]    chan;
  } seqStrobe_t;

  typedef struct packed {
    logic        [7:0]        sel;
    logic signed [DATA_W-1:0] gain;
    logic signed [DATA_W-1:0] offset;
    logic signed [DATA_W-1:0] minV;
    logic signed [DATA_W-1:0] maxV;
  } chanCfg_t;

  localparam chanCfg_t CFG_RESET = '{
    sel:    8'd0,
    gain:   16'sh0000,
    offset: 16'sh0000,
    minV:   16'sh8000,
    maxV:   16'sh7FFF
  };

endpackage

// File: rtl/aout_router_ctrl.sv
module aout_router_ctrl
  import aout_router_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  output seqStrobe_t strobe
);

  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic            busy;
  logic [CH_W-1:0] chanIdx;
  logic            commit;

  assign commit = sampleTick && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      chanIdx <= '0;
    end else if (commit) begin
      busy    <= 1'b1;
      chanIdx <= '0;
    end else if (busy) begin
      if (chanIdx == LAST_CH) begin
        busy    <= 1'b0;
        chanIdx <= '0;
      end else begin
        chanIdx <= chanIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.commit = commit;
    strobe.issue  = busy;
    strobe.chan   = CHAN_W_MAX'(chanIdx);
  end

  assert_seq_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> strobe.issue && (strobe.chan == '0));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !sampleTick && strobe.chan != CHAN_W_MAX'(LAST_CH))
      |=> strobe.issue && (strobe.chan == $past(strobe.chan) + 1'b1));

  assert_seq_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.chan == CHAN_W_MAX'(LAST_CH)) |=> !strobe.issue);

  assert_tick_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && sampleTick && strobe.chan != CHAN_W_MAX'(LAST_CH))
      |=> strobe.chan == $past(strobe.chan) + 1'b1);

endmodule

// File: rtl/aout_router_cfg.sv
module aout_router_cfg
  import aout_router_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic                     cfgWrEn,
  input  logic [$clog2(NUM_CH)-1:0] cfgChan,
  input  logic [2:0]               cfgField,
  input  logic [DATA_W-1:0]        cfgData,
  output chanCfg_t                 curCfg
);

  localparam int CH_W = $clog2(NUM_CH);

  chanCfg_t shadowCfg [NUM_CH];
  chanCfg_t activeCfg [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        shadowCfg[i] <= CFG_RESET;
        activeCfg[i] <= CFG_RESET;
      end
    end else begin
      if (cfgWrEn) begin
        case (cfgField)
          FLD_SEL:    shadowCfg[cfgChan].sel    <= cfgData[7:0];
          FLD_GAIN:   shadowCfg[cfgChan].gain   <= cfgData;
          FLD_OFFSET: shadowCfg[cfgChan].offset <= cfgData;
          FLD_MIN:    shadowCfg[cfgChan].minV   <= cfgData;
          FLD_MAX:    shadowCfg[cfgChan].maxV   <= cfgData;
          default: ;
        endcase
      end
      if (strobe.commit) begin
        for (int i = 0; i < NUM_CH; i++) begin
          activeCfg[i] <= shadowCfg[i];
        end
      end
    end
  end

  assign curCfg = activeCfg[strobe.chan[CH_W-1:0]];

  // R9: the working copy takes the shadow copy exactly at an accepted tick
  assert_commit_copy_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> activeCfg[0] == $past(shadowCfg[0]));

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(activeCfg[NUM_CH-1]));

endmodule

// File: rtl/aout_router_dp.sv
module aout_router_dp
  import aout_router_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int NUM_MEAS = 8,
  parameter int NUM_USER = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strobe,
  input  chanCfg_t                     curCfg,
  input  logic [NUM_MEAS*DATA_W-1:0]   measIn,
  input  logic [NUM_USER*DATA_W-1:0]   userIn,
  output logic                         resValid,
  output logic [$clog2(NUM_CH)-1:0]    resChan,
  output logic [DATA_W-1:0]            resData
);

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int NUM_SRC = NUM_MEAS + NUM_USER;
  localparam int SEL_W  = $clog2(NUM_SRC);
  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = PROD_W + 2;

  logic signed [DATA_W-1:0] snap [NUM_SRC];

  for (genvar m = 0; m < NUM_MEAS; m++) begin : g_meas
    always_ff @(posedge clk) begin
      if (!rstN)              snap[m] <= '0;
      else if (strobe.commit) snap[m] <= measIn[m*DATA_W +: DATA_W];
    end
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    always_ff @(posedge clk) begin
      if (!rstN)              snap[NUM_MEAS+u] <= '0;
      else if (strobe.commit) snap[NUM_MEAS+u] <= userIn[u*DATA_W +: DATA_W];
    end
  end

  logic signed [DATA_W-1:0] srcVal;
  always_comb begin
    if (int'(curCfg.sel) < NUM_SRC) srcVal = snap[curCfg.sel[SEL_W-1:0]];
    else                             srcVal = '0;
  end

  // Stage A: full-width product with bounds carried alongside
  logic                     validA;
  logic [CH_W-1:0]          chanA;
  logic signed [PROD_W-1:0] prodA;
  logic signed [DATA_W-1:0] offA, minA, maxA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validA <= 1'b0;
      chanA  <= '0;
      prodA  <= '0;
      offA   <= '0;
      minA   <= '0;
      maxA   <= '0;
    end else begin
      validA <= strobe.issue;
      chanA  <= strobe.chan[CH_W-1:0];
      prodA  <= PROD_W'(srcVal) * PROD_W'(curCfg.gain);
      offA   <= curCfg.offset;
      minA   <= curCfg.minV;
      maxA   <= curCfg.maxV;
    end
  end

  // Stage B: offset add, lower bound first, upper bound last
  logic signed [SUM_W-1:0] sumB, minB, maxB, lowB, limB;

  always_comb begin
    sumB = SUM_W'(prodA) + {{(SUM_W-DATA_W-FRAC_W){offA[DATA_W-1]}}, offA, {FRAC_W{1'b0}}};
    minB = {{(SUM_W-DATA_W-FRAC_W){minA[DATA_W-1]}}, minA, {FRAC_W{1'b0}}};
    maxB = {{(SUM_W-DATA_W-FRAC_W){maxA[DATA_W-1]}}, maxA, {FRAC_W{1'b0}}};
    lowB = (sumB < minB) ? minB : sumB;
    limB = (lowB > maxB) ? maxB : lowB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resChan  <= '0;
      resData  <= '0;
    end else begin
      resValid <= validA;
      resChan  <= chanA;
      resData  <= DATA_W'(limB >>> FRAC_W);
    end
  end

  assert_under_max_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $signed(resData) <= $past(maxA));

  assert_over_min_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(minA) <= $past(maxA)) |-> $signed(resData) >= $past(minA));

  assert_inverted_bounds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(minA) > $past(maxA)) |-> $signed(resData) == $past(maxA));

  assert_pipe_follows_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    validA |=> resValid && (resChan == $past(chanA)));

endmodule

// File: rtl/aout_router.sv
module aout_router
  import aout_router_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int NUM_MEAS = 8,
  parameter int NUM_USER = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleTick,
  input  logic [NUM_MEAS*16-1:0]       measIn,
  input  logic [NUM_USER*16-1:0]       userIn,
  input  logic                         cfgWrEn,
  input  logic [$clog2(NUM_CH)-1:0]    cfgChan,
  input  logic [2:0]                   cfgField,
  input  logic [15:0]                  cfgData,
  output logic                         resValid,
  output logic [$clog2(NUM_CH)-1:0]    resChan,
  output logic [15:0]                  resData
);

  initial begin
    if (NUM_CH != 16 && NUM_CH != 32) $error("NUM_CH must be 16 or 32");
    if (NUM_MEAS + NUM_USER > 256)     $error("source pool exceeds 8-bit select");
  end

  seqStrobe_t strobe;
  chanCfg_t   curCfg;

  aout_router_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .strobe     (strobe)
  );

  aout_router_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWrEn  (cfgWrEn),
    .cfgChan  (cfgChan),
    .cfgField (cfgField),
    .cfgData  (cfgData),
    .curCfg   (curCfg)
  );

  aout_router_dp #(.NUM_CH(NUM_CH), .NUM_MEAS(NUM_MEAS), .NUM_USER(NUM_USER)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curCfg   (curCfg),
    .measIn   (measIn),
    .userIn   (userIn),
    .resValid (resValid),
    .resChan  (resChan),
    .resData  (resData)
  );

endmodule

// File: tb/aout_router_test.sv
`timescale 1ns/1ps
module aout_router_test;

  localparam int NUM_CH   = 32;
  localparam int NUM_MEAS = 8;
  localparam int NUM_USER = 4;
  localparam int NUM_SRC  = NUM_MEAS + NUM_USER;
  localparam int CH_W     = $clog2(NUM_CH);

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    sampleTick = 1'b0;
  logic [NUM_MEAS*16-1:0]  measIn = '0;
  logic [NUM_USER*16-1:0]  userIn = '0;
  logic                    cfgWrEn = 1'b0;
  logic [CH_W-1:0]         cfgChan = '0;
  logic [2:0]              cfgField = '0;
  logic [15:0]             cfgData = '0;
  logic                    resValid;
  logic [CH_W-1:0]         resChan;
  logic [15:0]             resData;

  always #10 clk = ~clk;

  aout_router #(.NUM_CH(NUM_CH), .NUM_MEAS(NUM_MEAS), .NUM_USER(NUM_USER)) uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .measIn(measIn), .userIn(userIn),
    .cfgWrEn(cfgWrEn), .cfgChan(cfgChan), .cfgField(cfgField), .cfgData(cfgData),
    .resValid(resValid), .resChan(resChan), .resData(resData)
  );

  typedef struct { int chan; int data; string tag; } expItem_t;
  expItem_t expQ[$];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // requirement-level model
  int shSel[NUM_CH], shGain[NUM_CH], shOff[NUM_CH], shMin[NUM_CH], shMax[NUM_CH];
  int acSel[NUM_CH], acGain[NUM_CH], acOff[NUM_CH], acMin[NUM_CH], acMax[NUM_CH];
  int pool[NUM_SRC];
  int snapPool[NUM_SRC];
  string chanTag[NUM_CH];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expOut(input int ch);
    longint src, s, lo, hi, t;
    src = (acSel[ch] < NUM_SRC) ? longint'(snapPool[acSel[ch]]) : 0;
    s  = src * longint'(acGain[ch]) + longint'(acOff[ch]) * 4096;
    lo = longint'(acMin[ch]) * 4096;
    hi = longint'(acMax[ch]) * 4096;
    t  = (s < lo) ? lo : s;
    if (t > hi) t = hi;
    return int'(t >>> 12);
  endfunction

  task automatic modelCommit();
    for (int i = 0; i < NUM_CH; i++) begin
      acSel[i] = shSel[i]; acGain[i] = shGain[i]; acOff[i] = shOff[i];
      acMin[i] = shMin[i]; acMax[i] = shMax[i];
    end
    for (int s = 0; s < NUM_SRC; s++) snapPool[s] = pool[s];
    for (int i = 0; i < NUM_CH; i++) begin
      expItem_t it;
      it.chan = i; it.data = expOut(i); it.tag = chanTag[i];
      expQ.push_back(it);
    end
  endtask

  function automatic int sx16(input int v);
    logic [15:0] b;
    b = 16'(v);
    return int'($signed(b));
  endfunction

  task automatic modelWrite(input int ch, input int f, input int v);
    case (f)
      0: shSel[ch]  = v & 255;
      1: shGain[ch] = sx16(v);
      2: shOff[ch]  = sx16(v);
      3: shMin[ch]  = sx16(v);
      4: shMax[ch]  = sx16(v);
      default: ;
    endcase
  endtask

  task automatic applyPool();
    for (int m = 0; m < NUM_MEAS; m++) measIn[m*16 +: 16] = 16'(pool[m]);
    for (int u = 0; u < NUM_USER; u++) userIn[u*16 +: 16] = 16'(pool[NUM_MEAS+u]);
  endtask

  task automatic cfgWrite(input int ch, input int f, input int v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgChan = CH_W'(ch); cfgField = 3'(f); cfgData = 16'(v);
    modelWrite(ch, f, v);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic tick(input bit modelled);
    @(negedge clk);
    sampleTick = 1'b1;
    if (modelled) modelCommit();
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic writeWithTick(input int ch, input int f, input int v);
    @(negedge clk);
    sampleTick = 1'b1;
    cfgWrEn = 1'b1; cfgChan = CH_W'(ch); cfgField = 3'(f); cfgData = 16'(v);
    modelCommit();
    modelWrite(ch, f, v);
    @(negedge clk);
    sampleTick = 1'b0; cfgWrEn = 1'b0;
  endtask

  task automatic waitSweep();
    repeat (NUM_CH + 6) @(negedge clk);
  endtask

  // monitor: pops the scoreboard as results appear
  bit prevValid = 0;
  int prevChan = 0;
  int resCount = 0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (resValid) begin
        resCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected result", int'(resChan), -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(int'(resChan) == it.chan, {it.tag, " channel order"}, int'(resChan), it.chan);
          check(int'($signed(resData)) == it.data, {it.tag, " value"}, int'($signed(resData)), it.data);
        end
        if (resChan != '0)
          check(prevValid && (prevChan == int'(resChan) - 1), "R2 consecutive results",
                prevChan, int'(resChan) - 1);
      end
      prevValid = resValid;
      prevChan  = int'(resChan);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin
      shSel[i] = 0; shGain[i] = 0; shOff[i] = 0; shMin[i] = -32768; shMax[i] = 32767;
      chanTag[i] = "R2";
    end
    for (int s = 0; s < NUM_SRC; s++) pool[s] = 0;

    repeat (3) @(negedge clk);
    check(resValid == 1'b0, "R1 valid low in reset", int'(resValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(resValid == 1'b0, "R1 valid low after reset", int'(resValid), 0);

    // R1: first sweep yields reset outputs, even with nonzero inputs
    for (int i = 0; i < NUM_CH; i++) chanTag[i] = "R1";
    pool[0] = 1234; pool[3] = -999; applyPool();
    tick(1);
    waitSweep();
    for (int i = 0; i < NUM_CH; i++) chanTag[i] = "R2";

    // main pattern
    pool[0] = 2048; pool[1] = 20000; pool[2] = -3000;
    pool[NUM_MEAS] = 1024; pool[NUM_MEAS+1] = -7; applyPool();
    cfgWrite(0, 0, 0);  cfgWrite(0, 1, 4096);  chanTag[0] = "R4";
    cfgWrite(1, 0, 0);  cfgWrite(1, 1, -4096); chanTag[1] = "R6 inverted copy";
    cfgWrite(2, 0, NUM_MEAS); cfgWrite(2, 1, 8192); cfgWrite(2, 2, 2048); chanTag[2] = "R6 gain then offset";
    cfgWrite(3, 0, 13); cfgWrite(3, 1, 4096); cfgWrite(3, 2, 100); chanTag[3] = "R5 out of range source";
    cfgWrite(4, 0, 1);  cfgWrite(4, 1, 8192); cfgWrite(4, 4, 30000); chanTag[4] = "R7 upper bound";
    cfgWrite(5, 0, 2);  cfgWrite(5, 1, 4096); cfgWrite(5, 3, -1000); chanTag[5] = "R7 lower bound";
    cfgWrite(6, 0, 0);  cfgWrite(6, 1, 4096); cfgWrite(6, 3, 500); cfgWrite(6, 4, 200);
    chanTag[6] = "R8 inverted bounds";
    cfgWrite(7, 0, NUM_MEAS+1); cfgWrite(7, 1, 4096);
    cfgWrite(7, 5, 16'h7777); cfgWrite(7, 6, 16'h1111); cfgWrite(7, 7, 16'h2222);
    chanTag[7] = "R9 unused field codes";
    cfgWrite(8, 0, NUM_MEAS+1); cfgWrite(8, 1, 2048); chanTag[8] = "R6 floor rounding";
    cfgWrite(9, 0, 1); cfgWrite(9, 1, 4096); chanTag[9] = "R4 shared source";
    cfgWrite(10, 0, 1); cfgWrite(10, 1, -2048); cfgWrite(10, 2, -3); chanTag[10] = "R4 shared source";
    tick(1);
    // R4: inputs changed during the sweep must not be seen
    @(negedge clk);
    pool[0] = -5000; pool[1] = 77; pool[NUM_MEAS] = 300; applyPool();
    // R10: write during sweep, used only from the next sweep
    cfgWrite(31, 0, 0); cfgWrite(31, 1, 4096); chanTag[31] = "R10 write during sweep";
    // R3: extra tick inside the running sweep
    tick(0);
    waitSweep();

    // second sweep: new inputs, channel 31 now active
    tick(1);
    waitSweep();

    // same-edge write and tick: old value this sweep, new value next
    chanTag[0] = "R9 same-edge write";
    writeWithTick(0, 1, -8192);
    waitSweep();
    tick(1);
    waitSweep();

    // R3: ticks back to back
    for (int i = 0; i < NUM_CH; i++) chanTag[i] = "R3 back-to-back ticks";
    tick(1);
    tick(0);
    tick(0);
    waitSweep();

    check(expQ.size() == 0, "R2 all expected results seen", expQ.size(), 0);
    check(resCount == 6 * NUM_CH, "R3 result count", resCount, 6 * NUM_CH);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule